// File: doc/BRIEF.md
# Core Sleep and Wake-Up Controller

This block sits beside the pipelines of a small processor cluster and decides, per core, when a core stops issuing instructions after a decoded wait hint and when it resumes. Each core owns a one-bit pending-event flag. A send-event hint from any core, or a pulse on the cluster's incoming event line, sets the flag in every core. A wait-for-event hint either consumes a set flag and carries on at once, or puts the core to sleep until a qualified wake source appears. A wait-for-interrupt hint always sleeps and wakes on a wider set of sources that ignores most masks.

The pipeline sees a registered stall level and a one-cycle wake strobe per core. Thread-scheduling hardware sees a one-cycle yield pulse. Other clusters see a registered outbound event line. Every core's hint strobes, interrupt-style requests and mask bits arrive as bit vectors indexed by core number. A build parameter can turn the hint support off. The block then treats every hint as a no-op.

Top module: `swc_cluster`

## Requirements
- R1: After reset every stall, wake and yield output and the outbound event line read 0, and every pending-event flag is clear, so the first wait-for-event on any core sleeps.
- R2: A wait-for-event strobe on a running core whose pending-event flag is set leaves stall at 0 and clears the flag, so the next wait-for-event on that core sleeps.
- R3: A wait-for-event strobe on a running core whose flag is clear raises that core's stall on the following clock edge and leaves other cores running.
- R4: A core asleep on wait-for-event wakes on any of these: IRQ with its IRQ mask at 0; FIQ with its FIQ mask at 0; imprecise abort with its abort mask at 0; debug request with debug enabled; any event set request. A source that its qualifier blocks does not wake the core.
- R5: A core asleep on wait-for-interrupt wakes on IRQ or FIQ whatever their masks, on a debug request whatever the debug-enable bit, and on an abort only when the abort mask is 0.
- R6: A core asleep on wait-for-interrupt does not wake on an event. It does not read or clear its flag, but an event that arrives during this sleep still sets the flag.
- R7: A send-event strobe on any core drives the outbound event line to 1 for one cycle on the next edge and sets the flag in every core. A pulse on the incoming event line sets every flag and does not drive the outbound line.
- R8: When a flag set request and a wait-for-event clear of that flag fall in the same cycle, the flag ends up set.
- R9: When a sleeping core's wake condition holds in a cycle, stall falls and wake rises on the next edge. Wake stays high for exactly one cycle.
- R10: A yield strobe on a running core gives a one-cycle yield pulse on the next edge and never raises stall.
- R11: With hint support turned off, no hint raises stall, yield or the outbound event line.
- R12: Hint strobes that reach a sleeping core have no effect. Stall stays high and no yield pulse appears.
- R13: When a wait-for-interrupt and a wait-for-event strobe arrive together, the core sleeps under the wait-for-interrupt wake rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hint_wfe_i | input | NUM_CORES | Wait-for-event strobe per core |
| hint_wfi_i | input | NUM_CORES | Wait-for-interrupt strobe per core |
| hint_sev_i | input | NUM_CORES | Send-event strobe per core |
| hint_yield_i | input | NUM_CORES | Yield strobe per core |
| irq_i | input | NUM_CORES | IRQ request level per core |
| fiq_i | input | NUM_CORES | FIQ request level per core |
| abort_i | input | NUM_CORES | Imprecise abort request level per core |
| dbg_req_i | input | NUM_CORES | Debug entry request level per core |
| irq_mask_i | input | NUM_CORES | IRQ mask per core (1 = masked) |
| fiq_mask_i | input | NUM_CORES | FIQ mask per core (1 = masked) |
| abt_mask_i | input | NUM_CORES | Abort mask per core (1 = masked) |
| dbg_en_i | input | NUM_CORES | Debug enable per core |
| evt_in_i | input | 1 | Incoming event pulse from outside the cluster |
| stall_o | output | NUM_CORES | Registered sleep/stall level per core |
| wake_o | output | NUM_CORES | One-cycle wake strobe per core |
| yield_o | output | NUM_CORES | One-cycle yield pulse per core |
| evt_out_o | output | 1 | Registered outbound event pulse |

## Verification
The bench builds two copies side by side. The main copy has four cores with hint support on. A send-event can start from each of those four cores, so all sixteen source-to-destination paths of the event set are exercised, along with cross-core wake-up while other cores sleep. The second copy has two cores with hint support off. It receives the same strobes, which shows that the no-op variant chosen by the generate branch never stalls, yields or broadcasts.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_WFE = 2'd1,
    ST_WFI = 2'd2
  } swc_state_e;

  typedef struct packed {
    logic irq;
    logic fiq;
    logic abort;
    logic dbg_req;
    logic irq_mask;
    logic fiq_mask;
    logic abt_mask;
    logic dbg_en;
  } swc_wake_src_t;

endpackage

// File: rtl/swc_wake_eval.sv
module swc_wake_eval
  import swc_pkg::*;
(
  input  swc_wake_src_t src_i,
  input  logic          evt_pend_i,
  output logic          wfe_wake_o,
  output logic          wfi_wake_o
);

  logic abt_live;

  always_comb begin
    abt_live   = src_i.abort & ~src_i.abt_mask;
    // event wait: every qualifier applies
    wfe_wake_o = (src_i.irq & ~src_i.irq_mask) |
                 (src_i.fiq & ~src_i.fiq_mask) |
                 abt_live |
                 (src_i.dbg_req & src_i.dbg_en) |
                 evt_pend_i;
    // interrupt wait: only the abort mask applies
    wfi_wake_o = src_i.irq | src_i.fiq | abt_live | src_i.dbg_req;
  end

endmodule

// File: rtl/swc_event_hub.sv
module swc_event_hub #(
  parameter int NUM_CORES = 4,
  parameter bit HINTS_ON  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] sev_i,
  input  logic                 evt_in_i,
  output logic                 set_req_o,
  output logic                 evt_out_o
);

  logic any_sev;

  generate
    if (HINTS_ON) begin : g_live
      assign any_sev   = |sev_i;
      assign set_req_o = any_sev | evt_in_i;
    end else begin : g_nop
      assign any_sev   = 1'b0;
      assign set_req_o = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) evt_out_o <= 1'b0;
    else     evt_out_o <= any_sev;
  end

  generate
    if (HINTS_ON) begin : g_chk
      p_bcast_out_r7: assert property (@(posedge clk) disable iff (rst)
        (|sev_i) |=> evt_out_o)
        else $error("send-event not broadcast");
      p_bcast_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (!(|sev_i)) |=> !evt_out_o)
        else $error("outbound event without send-event");
    end else begin : g_chk_nop
      p_bcast_off_r11: assert property (@(posedge clk) disable iff (rst)
        !evt_out_o)
        else $error("outbound event with hints off");
    end
  endgenerate

endmodule

// File: rtl/swc_core_ctrl.sv
module swc_core_ctrl
  import swc_pkg::*;
#(
  parameter bit HINTS_ON = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wfe_i,
  input  logic          wfi_i,
  input  logic          yield_i,
  input  swc_wake_src_t src_i,
  input  logic          set_req_i,
  output logic          stall_o,
  output logic          wake_o,
  output logic          yield_o
);

  swc_state_e state_q, state_d;
  logic       evt_latch_q, evt_latch_d;
  logic       running, hit_clear;
  logic       wfe_wake, wfi_wake;

  swc_wake_eval u_eval (
    .src_i      (src_i),
    .evt_pend_i (evt_latch_q | set_req_i),
    .wfe_wake_o (wfe_wake),
    .wfi_wake_o (wfi_wake)
  );

  assign running   = (state_q == ST_RUN);
  assign hit_clear = HINTS_ON && running && wfe_i && !wfi_i && evt_latch_q;

  // set beats clear so no event is lost
  always_comb begin
    if (set_req_i)      evt_latch_d = 1'b1;
    else if (hit_clear) evt_latch_d = 1'b0;
    else                evt_latch_d = evt_latch_q;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (HINTS_ON) begin
          if (wfi_i)                       state_d = ST_WFI;
          else if (wfe_i && !evt_latch_q)  state_d = ST_WFE;
        end
      end
      ST_WFE:  if (wfe_wake) state_d = ST_RUN;
      ST_WFI:  if (wfi_wake) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      evt_latch_q <= 1'b0;
      stall_o     <= 1'b0;
      wake_o      <= 1'b0;
      yield_o     <= 1'b0;
    end else begin
      state_q     <= state_d;
      evt_latch_q <= evt_latch_d;
      stall_o     <= (state_d != ST_RUN);
      wake_o      <= !running && (state_d == ST_RUN);
      yield_o     <= HINTS_ON && running && yield_i && !wfe_i && !wfi_i;
    end
  end

  p_wake_single_r9: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o)
    else $error("wake strobe longer than one cycle");
  p_wake_ends_stall_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_o) |-> (!stall_o && $past(stall_o)))
    else $error("wake without end of stall");
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    set_req_i |=> evt_latch_q)
    else $error("event set request lost");
  p_wfi_keeps_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WFI && !set_req_i) |=> $stable(evt_latch_q))
    else $error("interrupt wait changed the event flag");
  p_hit_no_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (running && wfe_i && !wfi_i && evt_latch_q) |=> !stall_o)
    else $error("event wait slept with flag set");
  p_asleep_no_yield_r12: assert property (@(posedge clk) disable iff (rst)
    !running |=> !yield_o)
    else $error("yield pulse from sleeping core");

  generate
    if (!HINTS_ON) begin : g_nop_chk
      p_nop_r11: assert property (@(posedge clk) disable iff (rst)
        !stall_o && !yield_o && !evt_latch_q)
        else $error("hint acted with hints off");
    end
  endgenerate

endmodule

// File: rtl/swc_cluster.sv
module swc_cluster
  import swc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter bit HINTS_ON  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] hint_wfe_i,
  input  logic [NUM_CORES-1:0] hint_wfi_i,
  input  logic [NUM_CORES-1:0] hint_sev_i,
  input  logic [NUM_CORES-1:0] hint_yield_i,
  input  logic [NUM_CORES-1:0] irq_i,
  input  logic [NUM_CORES-1:0] fiq_i,
  input  logic [NUM_CORES-1:0] abort_i,
  input  logic [NUM_CORES-1:0] dbg_req_i,
  input  logic [NUM_CORES-1:0] irq_mask_i,
  input  logic [NUM_CORES-1:0] fiq_mask_i,
  input  logic [NUM_CORES-1:0] abt_mask_i,
  input  logic [NUM_CORES-1:0] dbg_en_i,
  input  logic                 evt_in_i,
  output logic [NUM_CORES-1:0] stall_o,
  output logic [NUM_CORES-1:0] wake_o,
  output logic [NUM_CORES-1:0] yield_o,
  output logic                 evt_out_o
);

  logic set_req;

  swc_event_hub #(
    .NUM_CORES (NUM_CORES),
    .HINTS_ON  (HINTS_ON)
  ) u_hub (
    .clk       (clk),
    .rst       (rst),
    .sev_i     (hint_sev_i),
    .evt_in_i  (evt_in_i),
    .set_req_o (set_req),
    .evt_out_o (evt_out_o)
  );

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      swc_wake_src_t src;
      assign src = '{irq:      irq_i[c],
                     fiq:      fiq_i[c],
                     abort:    abort_i[c],
                     dbg_req:  dbg_req_i[c],
                     irq_mask: irq_mask_i[c],
                     fiq_mask: fiq_mask_i[c],
                     abt_mask: abt_mask_i[c],
                     dbg_en:   dbg_en_i[c]};

      swc_core_ctrl #(
        .HINTS_ON (HINTS_ON)
      ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wfe_i     (hint_wfe_i[c]),
        .wfi_i     (hint_wfi_i[c]),
        .yield_i   (hint_yield_i[c]),
        .src_i     (src),
        .set_req_i (set_req),
        .stall_o   (stall_o[c]),
        .wake_o    (wake_o[c]),
        .yield_o   (yield_o[c])
      );
    end
  endgenerate

  p_stall_wake_excl_r9: assert property (@(posedge clk) disable iff (rst)
    (stall_o & wake_o) == '0)
    else $error("stall and wake together");

endmodule

// File: tb/swc_cluster_tb.sv
module swc_cluster_tb;

  localparam int N  = 4;
  localparam int N2 = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] wfe = '0, wfi = '0, sev = '0, yld = '0;
  logic [N-1:0] irq = '0, fiq = '0, abt = '0, dbg = '0;
  logic [N-1:0] mi = '0, mf = '0, ma = '0, den = '0;
  logic evt_in = 1'b0;
  logic [N-1:0] stall, wake, yout;
  logic evt_out;
  logic [N2-1:0] stall2, wake2, yout2;
  logic evt_out2;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  swc_cluster #(.NUM_CORES(N), .HINTS_ON(1'b1)) u_dut (
    .clk(clk), .rst(rst),
    .hint_wfe_i(wfe), .hint_wfi_i(wfi), .hint_sev_i(sev), .hint_yield_i(yld),
    .irq_i(irq), .fiq_i(fiq), .abort_i(abt), .dbg_req_i(dbg),
    .irq_mask_i(mi), .fiq_mask_i(mf), .abt_mask_i(ma), .dbg_en_i(den),
    .evt_in_i(evt_in),
    .stall_o(stall), .wake_o(wake), .yield_o(yout), .evt_out_o(evt_out)
  );

  swc_cluster #(.NUM_CORES(N2), .HINTS_ON(1'b0)) u_dut_nop (
    .clk(clk), .rst(rst),
    .hint_wfe_i(wfe[N2-1:0]), .hint_wfi_i(wfi[N2-1:0]),
    .hint_sev_i(sev[N2-1:0]), .hint_yield_i(yld[N2-1:0]),
    .irq_i(irq[N2-1:0]), .fiq_i(fiq[N2-1:0]), .abort_i(abt[N2-1:0]),
    .dbg_req_i(dbg[N2-1:0]),
    .irq_mask_i(mi[N2-1:0]), .fiq_mask_i(mf[N2-1:0]),
    .abt_mask_i(ma[N2-1:0]), .dbg_en_i(den[N2-1:0]),
    .evt_in_i(evt_in),
    .stall_o(stall2), .wake_o(wake2), .yield_o(yout2), .evt_out_o(evt_out2)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // wake everyone still asleep, then consume every flag
  task automatic drain();
    for (int k = 0; k < 2; k++) begin
      irq = '1; step(); irq = '0;
      wfe = '1; step(); wfe = '0;
      irq = '1; step(); irq = '0; step();
    end
  endtask

  task automatic t_reset();
    check("R1 stall", stall, 0);
    check("R1 wake", wake, 0);
    check("R1 yield", yout, 0);
    check("R1 evt_out", evt_out, 0);
  endtask

  task automatic t_wfe_sleep();
    wfe = 4'b0001; step(); wfe = '0;
    check("R1 R3 first wfe sleeps", stall, 4'b0001);
    wfi = 4'b0001; yld = 4'b0001; wfe = 4'b0001; step();
    wfi = '0; yld = '0; wfe = '0;
    check("R12 stall kept", stall, 4'b0001);
    check("R12 no yield", yout, 0);
    irq = 4'b0001; step(); irq = '0;
    check("R9 stall drops", stall, 0);
    check("R9 wake pulse", wake, 4'b0001);
    step();
    check("R9 wake one cycle", wake, 0);
  endtask

  task automatic t_wfe_masks();
    wfe = 4'b0010; step(); wfe = '0;
    check("R3 core1 sleeps", stall, 4'b0010);
    mi = '1; mf = '1; ma = '1; den = '0;
    irq = 4'b0010; fiq = 4'b0010; abt = 4'b0010; dbg = 4'b0010;
    step(); step();
    check("R4 masked sources keep sleep", stall, 4'b0010);
    check("R4 no wake", wake, 0);
    irq = '0; fiq = '0; dbg = '0;
    ma = '0; step();
    check("R4 abort unmasked wakes", wake, 4'b0010);
    abt = '0; step();
    wfe = 4'b0010; step(); wfe = '0;
    dbg = 4'b0010; den = 4'b0010; step(); dbg = '0; den = '0;
    check("R4 debug enabled wakes", wake, 4'b0010);
    step();
    wfe = 4'b0010; step(); wfe = '0;
    mf = '0; fiq = 4'b0010; step(); fiq = '0;
    check("R4 fiq unmasked wakes", wake, 4'b0010);
    step();
    wfe = 4'b0010; step(); wfe = '0;
    mi = '0; irq = 4'b0010; step(); irq = '0;
    check("R4 irq unmasked wakes", wake, 4'b0010);
    mi = '0; mf = '0; ma = '0;
    step();
  endtask

  task automatic t_sev_each();
    for (int c = 0; c < N; c++) begin
      sev = '0; sev[c] = 1'b1; step(); sev = '0;
      check($sformatf("R7 evt_out from core%0d", c), evt_out, 1);
      step();
      check("R7 evt_out one cycle", evt_out, 0);
      wfe = '1; step(); wfe = '0;
      check($sformatf("R7 R2 all flags set by core%0d", c), stall, 0);
      wfe = '1; step(); wfe = '0;
      check("R2 flags consumed", stall, 4'hF);
      irq = '1; step(); irq = '0;
      check("R9 all wake", wake, 4'hF);
      step();
    end
  endtask

  task automatic t_evt_wake();
    wfe = 4'b0100; step(); wfe = '0;
    sev = 4'b1000; step(); sev = '0;
    check("R4 event wakes core2", wake, 4'b0100);
    check("R4 others running", stall, 0);
    step();
    drain();
    wfe = 4'b0100; step(); wfe = '0;
    evt_in = 1'b1; step(); evt_in = 1'b0;
    check("R7 incoming event wakes", wake, 4'b0100);
    check("R7 incoming not rebroadcast", evt_out, 0);
    step();
    drain();
  endtask

  task automatic t_wfi();
    wfi = 4'b0001; step(); wfi = '0;
    check("R5 wfi sleeps", stall, 4'b0001);
    mi = '1; irq = 4'b0001; step(); irq = '0; mi = '0;
    check("R5 masked irq wakes", wake, 4'b0001);
    step();
    wfi = 4'b0001; step(); wfi = '0;
    sev = 4'b0010; step(); sev = '0; step();
    check("R6 event does not wake", stall, 4'b0001);
    ma = '1; abt = 4'b0001; step(); abt = '0; ma = '0;
    check("R5 masked abort stays", stall, 4'b0001);
    den = '0; dbg = 4'b0001; step(); dbg = '0;
    check("R5 debug wakes without enable", wake, 4'b0001);
    step();
    wfe = 4'b0001; step(); wfe = '0;
    check("R6 flag set during wfi kept", stall, 0);
    wfi = 4'b0010; step(); wfi = '0;
    mf = '1; fiq = 4'b0010; step(); fiq = '0; mf = '0;
    check("R5 masked fiq wakes", wake, 4'b0010);
    step();
    wfi = 4'b0100; wfe = 4'b0100; step(); wfi = '0; wfe = '0;
    sev = 4'b0001; step(); sev = '0;
    check("R13 wfi wins over wfe", stall, 4'b0100);
    irq = 4'b0100; step(); irq = '0;
    check("R13 woken by irq", wake, 4'b0100);
    step();
    drain();
  endtask

  task automatic t_set_wins();
    sev = 4'b0010; step(); sev = '0;
    wfe = 4'b0010; sev = 4'b0100; step(); wfe = '0; sev = '0;
    check("R8 first wfe no stall", stall, 0);
    wfe = 4'b0010; step(); wfe = '0;
    check("R8 flag survived clear", stall, 0);
    wfe = 4'b0010; step(); wfe = '0;
    check("R8 third wfe sleeps", stall, 4'b0010);
    irq = 4'b0010; step(); irq = '0; step();
    drain();
  endtask

  task automatic t_yield();
    yld = 4'b1000; step(); yld = '0;
    check("R10 yield pulse", yout, 4'b1000);
    check("R10 no stall", stall, 0);
    step();
    check("R10 yield one cycle", yout, 0);
  endtask

  task automatic t_nop();
    wfe = 2'b11; wfi = 2'b01; sev = 2'b11; yld = 2'b10; step();
    wfe = '0; wfi = '0; sev = '0; yld = '0;
    check("R11 no stall", stall2, 0);
    check("R11 no yield", yout2, 0);
    check("R11 no event", evt_out2, 0);
    step();
    wfe = 2'b11; step(); wfe = '0;
    check("R11 still running", stall2, 0);
    check("R11 no wake", wake2, 0);
    drain();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      summary();
    end
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    step();
    t_reset();
    t_wfe_sleep();
    t_wfe_masks();
    t_sev_each();
    t_evt_wake();
    t_wfi();
    t_set_wins();
    t_yield();
    t_nop();
    summary();
  end

endmodule